// File: doc/BRIEF.md
# Ethernet controller register and interrupt bank

This block is the software-visible control face of a simple Ethernet controller. A 32-bit register bus reaches it with byte, halfword or word accesses. It stores the interrupt status and enable mask, the base addresses of the transmit and receive descriptor rings, a packed ring-size word, a transmit/receive control register and a small PHY management window. Writes to some of these registers have side effects. The status register is write-one-to-clear. Some control writes start a transmit pass, force an idle code or wipe the status. A read of the PHY data word is answered by a built-in stand-in PHY.

The DMA engines sit next to it. They take the ring bases and ring lengths from dedicated outputs. They receive a one-cycle kick when software starts a transmit pass, and they raise completion events that are merged into the status word. One level interrupt line is high whenever any interrupt is enabled and any status bit is pending.

Top module: `nic_regbank`

## Requirements
- R1: `size_i` codes an access as 0 = byte, 1 = halfword, 2 = word. `wdata_i` holds the value right-aligned. A write updates only the byte lanes it addresses; byte lane k is address offset k inside the word, little-endian. A read returns the addressed bytes right-aligned and zero-extended.
- R2: An access has no effect on any state if it is a halfword at an odd address, a word at an address that is not a multiple of four, or uses size code 3. A read of this kind returns zero. Offsets that are not mapped read zero and ignore writes.
- R3: A write to the status word (offset 0x000) clears each addressed bit written as one. It leaves the bits written as zero unchanged.
- R4: `tx_done_i` sets status bit 4 and `rx_done_i` sets status bit 1. Each set is applied in the same cycle as any software clear, and the set wins on the same bit.
- R5: `irq_o` is high exactly when the mask word (offset 0x004) is nonzero and the status word is nonzero, each tested as a whole. It follows the register state one cycle after the clock edge that changes it.
- R6: Offsets 0x100 and 0x104 hold the transmit and receive ring bases, which drive `tx_ring_base_o` and `rx_ring_base_o`. Offset 0x108 holds the transmit length minus one in bits 15:0 and the receive length minus one in bits 31:16. `tx_ring_len_o` and `rx_ring_len_o` present each field plus one.
- R7: A write to the control register (offset 0x144) whose right-aligned value is exactly 1 pulses `tx_kick_o` high for the single cycle that follows the write.
- R8: A control write with value bit 2 set makes the control register read 0x8. Otherwise, if bit 1 is set, the status word is cleared to zero and the control register keeps its old contents.
- R9: A control write of value zero sets bit 31 of offset 0x130 and leaves the control register unchanged, but only while offset 0x134 holds 0x00200010. Every other control write stores its value into the addressed lanes. Offsets 0x130 and 0x134 are otherwise plain storage.
- R10: A read of PHY control (offset 0x190) returns the stored value with bit 16 forced to zero. PHY status (offset 0x180) always reads zero. Writes to PHY data (offset 0x194) have no effect.
- R11: A read of PHY data returns all ones when PHY control bits 9:5 are not 1. For PHY address 1, the PHY register in control bits 4:0 selects the value: register 1 returns 0x0024, registers 4 and 5 return 0x03E0, and all others return zero.
- R12: `rvalid_o` and `rdata_o` are updated in the cycle after a read request. At any other time `rvalid_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address inside the window |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Right-aligned write value |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Right-aligned read value |
| tx_done_i | input | 1 | Transmit engine interrupt-set request |
| rx_done_i | input | 1 | Receive engine interrupt-set request |
| irq_o | output | 1 | Level interrupt |
| tx_kick_o | output | 1 | Start-transmit pulse |
| tx_ring_base_o | output | 32 | Transmit ring base address |
| rx_ring_base_o | output | 32 | Receive ring base address |
| tx_ring_len_o | output | 17 | Transmit ring length in descriptors |
| rx_ring_len_o | output | 17 | Receive ring length in descriptors |

## Verification
Every result of this block is due exactly one cycle after the access or engine request that causes it: read data and its valid flag, the kick pulse, the interrupt level and the ring outputs. The bench drives each access on a falling edge and advances its reference model by one step for that cycle. It then waits for the rising edge that registers the result and compares all outputs at the next falling edge. The model's state therefore always describes the same cycle as the design's outputs. Corner cases get dedicated steps: a clear and a set hitting the same status bit together, and the control-write priority among idle, status-wipe, unlock and store.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned NREG     = 11;
  localparam int unsigned IX_STAT  = 0;
  localparam int unsigned IX_MASK  = 1;
  localparam int unsigned IX_TXB   = 2;
  localparam int unsigned IX_RXB   = 3;
  localparam int unsigned IX_RSZ   = 4;
  localparam int unsigned IX_AUXA  = 5;
  localparam int unsigned IX_AUXB  = 6;
  localparam int unsigned IX_CTL   = 7;
  localparam int unsigned IX_MSTAT = 8;
  localparam int unsigned IX_MCTL  = 9;
  localparam int unsigned IX_MDATA = 10;

  localparam logic [31:0] UNLOCK_KEY  = 32'h0020_0010;
  localparam logic [31:0] CTL_IDLE    = 32'h0000_0008;
  localparam logic [31:0] PHY_STAT_V  = 32'h0000_0024;
  localparam logic [31:0] PHY_ABIL_V  = 32'h0000_03E0;
  localparam int unsigned MCTL_BUSY   = 16;

  function automatic int unsigned reg_ofs(input int unsigned ix);
    case (ix)
      IX_STAT:  return 'h000;
      IX_MASK:  return 'h004;
      IX_TXB:   return 'h100;
      IX_RXB:   return 'h104;
      IX_RSZ:   return 'h108;
      IX_AUXA:  return 'h130;
      IX_AUXB:  return 'h134;
      IX_CTL:   return 'h144;
      IX_MSTAT: return 'h180;
      IX_MCTL:  return 'h190;
      default:  return 'h194;
    endcase
  endfunction

endpackage

// File: rtl/nic_lane_reg.sv
module nic_lane_reg #(
  parameter int unsigned         NLANE = 4,
  parameter logic [8*NLANE-1:0]  RST   = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NLANE-1:0]   be_i,
  input  logic [8*NLANE-1:0] d_i,
  output logic [8*NLANE-1:0] q_o
);
  logic [7:0] lane_q [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                lane_q[g] <= RST[8*g +: 8];
      else if (we_i && be_i[g])   lane_q[g] <= d_i[8*g +: 8];
    end
    assign q_o[8*g +: 8] = lane_q[g];
  end
endmodule

// File: rtl/nic_bus_decode.sv
module nic_bus_decode
  import nic_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic              rd_any_o,
  output logic [1:0]        ofs_o,
  output logic [31:0]       vmask_o,
  output logic [31:0]       wval_o,
  output logic [31:0]       wlane_o,
  output logic [31:0]       bmask_o,
  output logic [3:0]        be_o,
  output logic [NREG-1:0]   sel_o
);
  logic              aligned;
  logic [ADDR_W-1:0] word_addr;
  logic [4:0]        shamt;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin aligned = 1'b1;                  vmask_o = 32'h0000_00FF; end
      SZ_HALF: begin aligned = ~addr_i[0];            vmask_o = 32'h0000_FFFF; end
      SZ_WORD: begin aligned = (addr_i[1:0] == 2'b00); vmask_o = 32'hFFFF_FFFF; end
      default: begin aligned = 1'b0;                  vmask_o = 32'h0;         end
    endcase
  end

  assign ofs_o     = addr_i[1:0];
  assign shamt     = {addr_i[1:0], 3'b000};
  assign word_addr = {addr_i[ADDR_W-1:2], 2'b00};
  assign wval_o    = wdata_i & vmask_o;
  assign wlane_o   = wval_o << shamt;
  assign bmask_o   = vmask_o << shamt;
  assign wr_o      = req_i & aligned & we_i;
  assign rd_o      = req_i & aligned & ~we_i;
  assign rd_any_o  = req_i & ~we_i;

  for (genvar l = 0; l < 4; l++) begin : g_be
    assign be_o[l] = bmask_o[8*l];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel_o[g] = req_i & aligned & (word_addr == ADDR_W'(reg_ofs(g)));
  end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stat_wr_i,
  input  logic        mask_wr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wlane_i,
  input  logic        clr_all_i,
  input  logic [31:0] set_i,
  output logic [31:0] status_o,
  output logic [31:0] mask_o,
  output logic        irq_o
);
  logic [31:0] status_q, status_d;
  logic        irq_q;

  nic_lane_reg #(.NLANE(4), .RST('0)) u_mask (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(mask_wr_i), .be_i(be_i),
    .d_i   (wlane_i), .q_o(mask_o)
  );

  always_comb begin
    status_d = status_q;
    if (stat_wr_i) status_d = status_d & ~wlane_i;
    if (clr_all_i) status_d = '0;
    status_d = status_d | set_i;
  end

  // mask takes effect with its own register update, so look at its next value
  logic [31:0] mask_next;
  always_comb begin
    mask_next = mask_o;
    for (int l = 0; l < 4; l++)
      if (mask_wr_i && be_i[l]) mask_next[8*l +: 8] = wlane_i[8*l +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= (|mask_next) & (|status_d);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));        // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !clr_all_i) |=> ((status_q & $past(wlane_i & ~set_i)) == 32'h0)); // R3
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((|mask_o) && (|status_q)));                               // R5
endmodule

// File: rtl/nic_mii_stub.sv
module nic_mii_stub
  import nic_regbank_pkg::*;
#(
  parameter int unsigned PHY_ADDR = 1
) (
  input  logic [31:0] mctl_i,
  output logic [31:0] data_o
);
  logic [4:0] phy_sel;
  logic [4:0] phy_reg;

  assign phy_sel = mctl_i[9:5];
  assign phy_reg = mctl_i[4:0];

  always_comb begin
    if (phy_sel != 5'(PHY_ADDR)) begin
      data_o = '1;
    end else begin
      unique case (phy_reg)
        5'd1:       data_o = PHY_STAT_V;
        5'd4, 5'd5: data_o = PHY_ABIL_V;
        default:    data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned RING_W     = 16,
  parameter int unsigned TX_IRQ_BIT = 4,
  parameter int unsigned RX_IRQ_BIT = 1,
  parameter int unsigned PHY_ADDR   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  output logic              irq_o,
  output logic              tx_kick_o,
  output logic [31:0]       tx_ring_base_o,
  output logic [31:0]       rx_ring_base_o,
  output logic [RING_W:0]   tx_ring_len_o,
  output logic [RING_W:0]   rx_ring_len_o
);
  localparam int unsigned LEN_W = RING_W + 1;

  logic            wr, rd, rd_any;
  logic [1:0]      ofs;
  logic [31:0]     vmask, wval, wlane, bmask;
  logic [3:0]      be;
  logic [NREG-1:0] sel;

  nic_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i),
    .wr_o(wr), .rd_o(rd), .rd_any_o(rd_any), .ofs_o(ofs), .vmask_o(vmask),
    .wval_o(wval), .wlane_o(wlane), .bmask_o(bmask), .be_o(be), .sel_o(sel)
  );

  // control-write decode, priority: idle > status wipe > unlock > store
  logic ctl_wr, ctl_idle, ctl_wipe, ctl_unlock, ctl_store, kick_d;
  logic [31:0] auxb_q;

  assign ctl_wr     = wr & sel[IX_CTL];
  assign ctl_idle   = wval[2];
  assign ctl_wipe   = ~wval[2] & wval[1];
  assign ctl_unlock = (wval == 32'h0) & (auxb_q == UNLOCK_KEY);
  assign ctl_store  = ~ctl_idle & ~ctl_wipe & ~ctl_unlock;
  assign kick_d     = ctl_wr & (wval == 32'h1);

  logic [31:0] set_vec;
  always_comb begin
    set_vec             = '0;
    set_vec[TX_IRQ_BIT] = tx_done_i;
    set_vec[RX_IRQ_BIT] = set_vec[RX_IRQ_BIT] | rx_done_i;
  end

  logic [31:0] status_q, mask_q;

  nic_irq_ctrl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stat_wr_i(wr & sel[IX_STAT]), .mask_wr_i(wr & sel[IX_MASK]),
    .be_i(be), .wlane_i(wlane), .clr_all_i(ctl_wr & ctl_wipe),
    .set_i(set_vec), .status_o(status_q), .mask_o(mask_q), .irq_o(irq_o)
  );

  logic [31:0] txb_q, rxb_q, rsz_q, mctl_q;

  nic_lane_reg #(.NLANE(4)) u_txb (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr & sel[IX_TXB]), .be_i(be), .d_i(wlane), .q_o(txb_q));
  nic_lane_reg #(.NLANE(4)) u_rxb (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr & sel[IX_RXB]), .be_i(be), .d_i(wlane), .q_o(rxb_q));
  nic_lane_reg #(.NLANE(4)) u_rsz (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr & sel[IX_RSZ]), .be_i(be), .d_i(wlane), .q_o(rsz_q));
  nic_lane_reg #(.NLANE(4)) u_auxb (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr & sel[IX_AUXB]), .be_i(be), .d_i(wlane), .q_o(auxb_q));
  nic_lane_reg #(.NLANE(4)) u_mctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr & sel[IX_MCTL]), .be_i(be), .d_i(wlane), .q_o(mctl_q));

  logic [31:0] auxa_q, ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auxa_q <= '0;
    end else if (wr & sel[IX_AUXA]) begin
      auxa_q <= (auxa_q & ~bmask) | wlane;
    end else if (ctl_wr & ~ctl_idle & ~ctl_wipe & ctl_unlock) begin
      auxa_q[31] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      if (ctl_idle)       ctl_q <= CTL_IDLE;
      else if (ctl_store) ctl_q <= (ctl_q & ~bmask) | wlane;
    end
  end

  logic [31:0] mii_data;
  nic_mii_stub #(.PHY_ADDR(PHY_ADDR)) u_mii (.mctl_i(mctl_q), .data_o(mii_data));

  logic [31:0] rd_word [NREG];
  assign rd_word[IX_STAT]  = status_q;
  assign rd_word[IX_MASK]  = mask_q;
  assign rd_word[IX_TXB]   = txb_q;
  assign rd_word[IX_RXB]   = rxb_q;
  assign rd_word[IX_RSZ]   = rsz_q;
  assign rd_word[IX_AUXA]  = auxa_q;
  assign rd_word[IX_AUXB]  = auxb_q;
  assign rd_word[IX_CTL]   = ctl_q;
  assign rd_word[IX_MSTAT] = '0;
  assign rd_word[IX_MCTL]  = mctl_q & ~(32'h1 << MCTL_BUSY);
  assign rd_word[IX_MDATA] = mii_data;

  logic [31:0] word_sel, rdata_d;
  always_comb begin
    word_sel = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) word_sel = rd_word[i];
    rdata_d = rd ? ((word_sel >> {ofs, 3'b000}) & vmask) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      tx_kick_o <= 1'b0;
    end else begin
      rvalid_o  <= rd_any;
      rdata_o   <= rdata_d;
      tx_kick_o <= kick_d;
    end
  end

  assign tx_ring_base_o = txb_q;
  assign rx_ring_base_o = rxb_q;
  assign tx_ring_len_o  = LEN_W'(rsz_q[RING_W-1:0]) + LEN_W'(1);
  assign rx_ring_len_o  = LEN_W'(rsz_q[16 +: RING_W]) + LEN_W'(1);

  AST_KICK_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_kick_o |-> $past(req_i && we_i && wdata_i[0]));                   // R7
  AST_RVALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o == $past(req_i && !we_i));                                   // R12
  AST_MISALIGN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == 2'd2 && addr_i[1:0] != 2'b00)
      |=> ($stable(txb_q) && $stable(ctl_q) && $stable(mctl_q) && $stable(rsz_q))); // R2
  AST_MCTL_BUSY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(rd && sel[IX_MCTL] && size_i == 2'd2)) |-> !rdata_o[MCTL_BUSY]); // R10
endmodule

// File: tb/nic_regbank_bench.sv
module nic_regbank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic        tx_done_i = 1'b0, rx_done_i = 1'b0;
  logic        rvalid_o, irq_o, tx_kick_o;
  logic [31:0] rdata_o, tx_ring_base_o, rx_ring_base_o;
  logic [16:0] tx_ring_len_o, rx_ring_len_o;

  nic_regbank u_nic_regbank (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .tx_done_i(tx_done_i), .rx_done_i(rx_done_i), .irq_o(irq_o), .tx_kick_o(tx_kick_o),
    .tx_ring_base_o(tx_ring_base_o), .rx_ring_base_o(rx_ring_base_o),
    .tx_ring_len_o(tx_ring_len_o), .rx_ring_len_o(rx_ring_len_o)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_st, m_mk, m_txb, m_rxb, m_rsz, m_aa, m_ab, m_ctl, m_mc;
  logic        e_kick, e_rv;
  logic [31:0] e_rd;

  function automatic logic [31:0] szmask(int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit bad_acc(int a, int sz);
    return (sz == 3) || (sz == 1 && a % 2 != 0) || (sz == 2 && a % 4 != 0);
  endfunction

  function automatic logic [31:0] phy_answer();
    if (m_mc[9:5] != 5'd1) return 32'hFFFF_FFFF;
    if (m_mc[4:0] == 5'd1) return 32'h24;
    if (m_mc[4:0] == 5'd4 || m_mc[4:0] == 5'd5) return 32'h3E0;
    return 32'h0;
  endfunction

  function automatic logic [31:0] mread(int a, int sz);
    logic [31:0] w;
    if (bad_acc(a, sz)) return 32'h0;
    case (a & ~3)
      'h000: w = m_st;   'h004: w = m_mk;
      'h100: w = m_txb;  'h104: w = m_rxb;  'h108: w = m_rsz;
      'h130: w = m_aa;   'h134: w = m_ab;   'h144: w = m_ctl;
      'h190: w = m_mc & 32'hFFFE_FFFF;
      'h194: w = phy_answer();
      default: w = 32'h0;
    endcase
    return (w >> (8 * (a % 4))) & szmask(sz);
  endfunction

  task automatic mwrite(int a, int sz, logic [31:0] d);
    logic [31:0] v, lm, lv;
    if (bad_acc(a, sz)) return;
    v  = d & szmask(sz);
    lm = szmask(sz) << (8 * (a % 4));
    lv = v << (8 * (a % 4));
    case (a & ~3)
      'h000: m_st = m_st & ~lv;
      'h004: m_mk  = (m_mk  & ~lm) | lv;
      'h100: m_txb = (m_txb & ~lm) | lv;
      'h104: m_rxb = (m_rxb & ~lm) | lv;
      'h108: m_rsz = (m_rsz & ~lm) | lv;
      'h130: m_aa  = (m_aa  & ~lm) | lv;
      'h134: m_ab  = (m_ab  & ~lm) | lv;
      'h190: m_mc  = (m_mc  & ~lm) | lv;
      'h144: begin
        if (v == 1) e_kick = 1'b1;
        if (v[2])                           m_ctl = 32'h8;
        else if (v[1])                      m_st  = 0;
        else if (v == 0 && m_ab == 32'h200010) m_aa = m_aa | 32'h8000_0000;
        else                                m_ctl = (m_ctl & ~lm) | lv;
      end
      default: ;
    endcase
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit rq, bit w, int a, int sz, logic [31:0] d, bit td, bit rdn, string tag);
    req_i = rq; we_i = w; addr_i = 10'(a); size_i = 2'(sz); wdata_i = d;
    tx_done_i = td; rx_done_i = rdn;
    e_kick = 1'b0;
    e_rv   = rq && !w;
    e_rd   = e_rv ? mread(a, sz) : 32'h0;
    if (rq && w) mwrite(a, sz, d);
    if (td)  m_st = m_st | 32'h10;
    if (rdn) m_st = m_st | 32'h02;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; tx_done_i = 1'b0; rx_done_i = 1'b0;
    cmp("R12", "rvalid", 32'(rvalid_o), 32'(e_rv));
    cmp(tag, "rdata", rdata_o, e_rd);
    cmp("R5", "irq", 32'(irq_o), 32'((m_mk != 0) && (m_st != 0)));
    cmp("R7", "kick", 32'(tx_kick_o), 32'(e_kick));
    cmp("R6", "tx_base", tx_ring_base_o, m_txb);
    cmp("R6", "rx_base", rx_ring_base_o, m_rxb);
    cmp("R6", "tx_len", 32'(tx_ring_len_o), 32'(m_rsz[15:0]) + 1);
    cmp("R6", "rx_len", 32'(rx_ring_len_o), 32'(m_rsz[31:16]) + 1);
  endtask

  task automatic wr(int a, int sz, logic [31:0] d, string tag);
    step(1, 1, a, sz, d, 0, 0, tag);
  endtask
  task automatic rd(int a, int sz, string tag);
    step(1, 0, a, sz, 0, 0, 0, tag);
  endtask

  initial begin
    #400_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    {m_st, m_mk, m_txb, m_rxb, m_rsz, m_aa, m_ab, m_ctl, m_mc} = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    step(0, 0, 0, 0, 0, 0, 0, "R12");
    rd('h000, 2, "R3");

    // plain storage and ring outputs (R6)
    wr('h100, 2, 32'h1234_5670, "R6");
    wr('h104, 2, 32'h89AB_CDE0, "R6");
    wr('h108, 2, 32'h0003_0001, "R6");
    rd('h108, 2, "R6");
    wr('h108, 2, 32'hFFFF_FFFF, "R6");
    // lane writes and right-aligned reads (R1)
    wr('h101, 0, 32'hFFFF_FFA5, "R1");
    wr('h106, 1, 32'h0000_BEEF, "R1");
    rd('h100, 2, "R1");
    rd('h107, 0, "R1");
    rd('h106, 1, "R1");
    rd('h10A, 1, "R1");
    // misaligned and unmapped (R2)
    wr('h101, 2, 32'hDEAD_BEEF, "R2");
    wr('h103, 1, 32'h0000_1111, "R2");
    wr('h100, 3, 32'h2222_2222, "R2");
    rd('h102, 2, "R2");
    rd('h105, 1, "R2");
    wr('h200, 2, 32'h5555_5555, "R2");
    rd('h200, 2, "R2");

    // status, sets, mask, irq (R3 R4 R5)
    step(0, 0, 0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, "R4");
    rd('h000, 2, "R4");
    wr('h004, 2, 32'h0000_0100, "R5");
    wr('h004, 2, 32'h0, "R5");
    wr('h004, 0, 32'h0000_0002, "R5");
    wr('h000, 2, 32'h0000_0002, "R3");
    rd('h000, 2, "R3");
    wr('h000, 0, 32'h0000_0000, "R3");
    step(1, 1, 'h000, 2, 32'h0000_0010, 1, 0, "R4");
    rd('h000, 2, "R4");
    wr('h001, 0, 32'h0000_00FF, "R3");
    wr('h000, 0, 32'h0000_00FF, "R3");
    rd('h000, 2, "R3");

    // control register side effects (R7 R8 R9)
    wr('h144, 2, 32'h1, "R7");
    rd('h144, 2, "R7");
    wr('h144, 2, 32'h1, "R7");
    wr('h144, 2, 32'h1, "R7");
    wr('h144, 2, 32'h5, "R8");
    rd('h144, 2, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R4");
    wr('h144, 2, 32'h2, "R8");
    rd('h000, 2, "R8");
    rd('h144, 2, "R8");
    step(1, 1, 'h144, 2, 32'h2, 0, 1, "R8");
    rd('h000, 2, "R8");
    wr('h144, 2, 32'h0, "R9");
    rd('h144, 2, "R9");
    wr('h134, 2, 32'h0020_0010, "R9");
    wr('h130, 2, 32'h0000_00C3, "R9");
    wr('h144, 2, 32'h30, "R9");
    wr('h144, 2, 32'h0, "R9");
    rd('h130, 2, "R9");
    rd('h144, 2, "R9");
    wr('h145, 0, 32'h1, "R7");
    wr('h144, 0, 32'h1, "R7");
    rd('h144, 2, "R7");

    // PHY window (R10 R11)
    wr('h190, 2, 32'h0001_0021, "R10");
    rd('h190, 2, "R10");
    rd('h192, 1, "R10");
    rd('h194, 2, "R11");
    wr('h190, 2, 32'h0000_0024, "R11");
    rd('h194, 2, "R11");
    wr('h190, 2, 32'h0000_0025, "R11");
    rd('h194, 2, "R11");
    rd('h194, 1, "R11");
    wr('h190, 2, 32'h0000_0027, "R11");
    rd('h194, 2, "R11");
    wr('h190, 2, 32'h0000_0020, "R11");
    rd('h194, 2, "R11");
    wr('h190, 2, 32'h0000_0041, "R11");
    rd('h194, 2, "R11");
    wr('h194, 2, 32'h0000_0021, "R10");
    rd('h194, 2, "R10");
    rd('h190, 2, "R10");
    wr('h180, 2, 32'hFFFF_FFFF, "R10");
    rd('h180, 2, "R10");

    step(0, 0, 0, 0, 0, 0, 0, "R12");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule